// File: doc/BRIEF.md
# Compare/PWM Timer-Counter

An 8-bit counter paced by a shared prescaler and compared every counter step against a compare register. In normal operation it counts up, either ignoring a compare match or clearing to zero on the step after a match. In PWM operation it either sweeps up and down between 0x00 and 0xFF or counts up and wraps at 0xFF. A single compare output bit is set, cleared or toggled by match events. It is driven onto the output pin only when the external direction input selects output and the output mode is not off. Otherwise the pin carries the ordinary port value.

Software reaches the block through a write port (strobe, 2-bit address, data) and a separate combinational read port. Address 0 is the control register, address 1 the counter, address 2 the compare register and address 3 is unused. The counting direction in PWM sweep operation is held by a two-state machine. The state `DIR_UP` moves to `DIR_DOWN` on a counter step taken at 0xFF. `DIR_DOWN` moves to `DIR_UP` on a step taken at 0x00. Any mode other than the sweep forces `DIR_UP`, and a counter write holds the current state.

Top module: `tmr8_cmp_pwm`

## Requirements
- R1: After reset the control register, counter, compare register and internal compare output bit are all zero, so `pin_out` equals `port_in`.
- R2: Control register layout: bit 0 PWM enable, bit 1 clear/wrap select, bits 3:2 output mode, bits 6:4 clock select, bit 7 reads as zero. Address 2 reads the most recently written compare value. Address 3 reads zero and writes to it change nothing.
- R3: Clock select: 1 steps every clock; 2, 3, 4 and 5 step once every 8, 64, 256 and 1024 clocks, on the clock where the count of clocks since reset release, modulo the divisor, equals divisor-1. Codes 0, 6 and 7 stop the counter.
- R4: Outside PWM with clear/wrap = 0, the counter increments on each step and wraps from 0xFF to 0x00, and a compare match leaves the count untouched.
- R5: Outside PWM with clear/wrap = 1, a step taken while the counter equals the compare value C loads 0x00, giving C-1, C, 0, 1. At divide-by-8 every value, C and the following 0 included, lasts 8 clocks.
- R6: Outside PWM, on the step where the counter equals the compare value, output mode 01 toggles the output bit, 10 clears it, 11 sets it, and 00 leaves it.
- R7: `pin_out` carries the compare output bit only while `pin_dir` = 1 and the output mode is not 00; otherwise it equals `port_in`.
- R8: PWM with clear/wrap = 0 sweeps up to 0xFF, then steps to 0xFE and down to 0x00, then steps to 0x01 and up again.
- R9: In the sweep, a match while counting up clears the bit and one while counting down sets it for mode 10. Mode 11 does the reverse, and modes 00 and 01 take no action.
- R10: PWM with clear/wrap = 1 counts up and wraps 0xFF to 0x00. For mode 10 the bit is cleared on a match and set on the wrap step. Mode 11 does the reverse. A match on the wrap step takes priority.
- R11: In PWM a compare write goes to a buffer, and the active compare value takes it on the step leaving 0xFF while counting up. Outside PWM a compare write is active on the next clock.
- R12: A counter write sets the counter on the next clock edge and overrides any step there. The step on the clock after it takes no match action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| pin_dir | input | 1 | Port direction, 1 = output |
| port_in | input | 1 | Ordinary port value used when the timer does not own the pin |
| pin_out | output | 1 | Output pin |

## Verification
On every cycle the assertions check several behaviours. A counter write lands exactly, a stopped or idle prescaler holds the count, and the clear-on-match lands on zero. They also check the sweep turning points, the blocked match after a write, the pin release when the direction is input, and that the active compare value is frozen between top steps in PWM. Prescaler phase, long sequences across wraps, the interplay of buffered compare updates with the pin waveform, and the mode-dependent pin actions over whole periods show up only in the bench scenarios. There a behavioural model compares the read port and the pin every clock.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [1:0] {
        OC_OFF    = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_LOW    = 2'b10,
        OC_HIGH   = 2'b11
    } oc_mode_e;

    typedef enum logic [1:0] {
        RUN_FREE,
        RUN_CLEAR,
        RUN_UPDN,
        RUN_WRAP
    } run_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic [2:0] clk_sel;
        oc_mode_e   oc_mode;
        logic       clr_wrap;
        logic       pwm_en;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;

    localparam int DIV_LOG2_MAX = 10;

    function automatic run_mode_e decode_mode(input ctrl_t c);
        if (!c.pwm_en) return c.clr_wrap ? RUN_CLEAR : RUN_FREE;
        return c.clr_wrap ? RUN_WRAP : RUN_UPDN;
    endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
    import tmr8_pkg::*;
#(
    parameter int PRESC_W = DIV_LOG2_MAX
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] clk_sel,
    output logic       tick
);
    localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

    logic [PRESC_W-1:0] pcnt_q;
    logic [PRESC_W-1:0] mask;
    logic               run;
    int unsigned        shamt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_q + ONE;
    end

    always_comb begin
        run   = 1'b1;
        shamt = 0;
        unique case (clk_sel)
            3'd1:    shamt = 0;
            3'd2:    shamt = 3;
            3'd3:    shamt = 6;
            3'd4:    shamt = 8;
            3'd5:    shamt = 10;
            default: run = 1'b0;
        endcase
        mask = (ONE << shamt) - ONE;
        tick = run && ((pcnt_q & mask) == mask);
    end

    a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 || clk_sel > 3'd5) |-> !tick);
    a_r3_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd1) |-> tick);
    a_r3_div8_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd2 && tick) |=> (clk_sel != 3'd2 || !tick));

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  run_mode_e        run_mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir,
    output logic             match,
    output logic             top_evt
);
    localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    dir_e             dir_q, dir_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             blk_q;

    assign match   = tick && !load && !blk_q && (cnt_q == cmp_val);
    assign top_evt = tick && !load && (cnt_q == TOP) && dir_q == DIR_UP &&
                     (run_mode == RUN_UPDN || run_mode == RUN_WRAP);
    assign cnt     = cnt_q;
    assign dir     = dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
            blk_q <= 1'b0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
            blk_q <= load;
        end
    end

    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else begin
            unique case (run_mode)
                RUN_FREE: begin
                    dir_d = DIR_UP;
                    if (tick) cnt_d = cnt_q + ONE;
                end
                RUN_CLEAR: begin
                    dir_d = DIR_UP;
                    if (tick) cnt_d = match ? ZERO : cnt_q + ONE;
                end
                RUN_UPDN: begin
                    if (tick) begin
                        unique case (dir_q)
                            DIR_UP: begin
                                if (cnt_q == TOP) begin
                                    cnt_d = TOP - ONE;
                                    dir_d = DIR_DOWN;
                                end else begin
                                    cnt_d = cnt_q + ONE;
                                end
                            end
                            DIR_DOWN: begin
                                if (cnt_q == ZERO) begin
                                    cnt_d = ONE;
                                    dir_d = DIR_UP;
                                end else begin
                                    cnt_d = cnt_q - ONE;
                                end
                            end
                        endcase
                    end
                end
                RUN_WRAP: begin
                    dir_d = DIR_UP;
                    if (tick) cnt_d = cnt_q + ONE;
                end
            endcase
        end
    end

    a_r12_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == RUN_CLEAR && tick && !load && !blk_q && cnt_q == cmp_val) |=> cnt_q == ZERO);
    a_r12_blocked_step: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_q && tick && !load && run_mode == RUN_CLEAR) |=> cnt_q == $past(cnt_q) + ONE);
    a_r8_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == RUN_UPDN && dir_q == DIR_UP && tick && !load && cnt_q == TOP)
        |=> (dir_q == DIR_DOWN && cnt_q == TOP - ONE));
    a_r8_turn_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == RUN_UPDN && dir_q == DIR_DOWN && tick && !load && cnt_q == ZERO)
        |=> (dir_q == DIR_UP && cnt_q == ONE));

endmodule

// File: rtl/tmr8_ocpin.sv
module tmr8_ocpin
    import tmr8_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  run_mode_e run_mode,
    input  oc_mode_e  oc_mode,
    input  dir_e      dir,
    input  logic      match,
    input  logic      top_evt,
    input  logic      pin_dir,
    input  logic      port_in,
    output logic      pin_out
);
    logic oc_q, oc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oc_q <= 1'b0;
        else        oc_q <= oc_d;
    end

    always_comb begin
        oc_d = oc_q;
        unique case (run_mode)
            RUN_FREE, RUN_CLEAR: begin
                if (match) begin
                    unique case (oc_mode)
                        OC_OFF:    oc_d = oc_q;
                        OC_TOGGLE: oc_d = !oc_q;
                        OC_LOW:    oc_d = 1'b0;
                        OC_HIGH:   oc_d = 1'b1;
                    endcase
                end
            end
            RUN_UPDN: begin
                if (match) begin
                    unique case (oc_mode)
                        OC_LOW:  oc_d = (dir == DIR_DOWN);
                        OC_HIGH: oc_d = (dir == DIR_UP);
                        default: oc_d = oc_q;
                    endcase
                end
            end
            RUN_WRAP: begin
                if (match) begin
                    if (oc_mode == OC_LOW)  oc_d = 1'b0;
                    if (oc_mode == OC_HIGH) oc_d = 1'b1;
                end else if (top_evt) begin
                    if (oc_mode == OC_LOW)  oc_d = 1'b1;
                    if (oc_mode == OC_HIGH) oc_d = 1'b0;
                end
            end
        endcase
    end

    assign pin_out = (pin_dir && oc_mode != OC_OFF) ? oc_q : port_in;

    a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_dir |-> pin_out == port_in);
    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_mode == RUN_FREE || run_mode == RUN_CLEAR) && match && oc_mode == OC_TOGGLE)
        |=> oc_q != $past(oc_q));
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_mode == RUN_FREE || run_mode == RUN_CLEAR) && match && oc_mode == OC_HIGH) |=> oc_q);
    a_r9_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == RUN_UPDN && match && oc_mode == OC_LOW && dir == DIR_UP) |=> !oc_q);
    a_r10_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode == RUN_WRAP && top_evt && !match && oc_mode == OC_LOW) |=> oc_q);

endmodule

// File: rtl/tmr8_cmp_pwm.sv
module tmr8_cmp_pwm
    import tmr8_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int PRESC_W = DIV_LOG2_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             pin_dir,
    input  logic             port_in,
    output logic             pin_out
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_buf_q, cmp_act_q;
    logic             wr_ctrl, wr_cnt, wr_cmp;
    run_mode_e        run_mode;
    logic             tick, match, top_evt;
    logic [CNT_W-1:0] cnt;
    dir_e             dir;

    assign wr_ctrl  = wr_en && wr_addr == ADDR_CTRL;
    assign wr_cnt   = wr_en && wr_addr == ADDR_CNT;
    assign wr_cmp   = wr_en && wr_addr == ADDR_CMP;
    assign run_mode = decode_mode(ctrl_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            cmp_buf_q <= '0;
            cmp_act_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_cmp) cmp_buf_q <= wr_data;
            if (wr_cmp && !ctrl_q.pwm_en) cmp_act_q <= wr_data;
            else if (top_evt)             cmp_act_q <= cmp_buf_q;
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_CNT:  rd_data = cnt;
            ADDR_CMP:  rd_data = cmp_buf_q;
            default:   rd_data = '0;
        endcase
    end

    tmr8_prescale #(.PRESC_W(PRESC_W)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (ctrl_q.clk_sel),
        .tick    (tick)
    );

    tmr8_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run_mode (run_mode),
        .load     (wr_cnt),
        .load_val (wr_data),
        .cmp_val  (cmp_act_q),
        .cnt      (cnt),
        .dir      (dir),
        .match    (match),
        .top_evt  (top_evt)
    );

    tmr8_ocpin i_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_mode (run_mode),
        .oc_mode  (ctrl_q.oc_mode),
        .dir      (dir),
        .match    (match),
        .top_evt  (top_evt),
        .pin_dir  (pin_dir),
        .port_in  (port_in),
        .pin_out  (pin_out)
    );

    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.pwm_en && !top_evt) |=> $stable(cmp_act_q));
    a_r11_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !ctrl_q.pwm_en) |=> cmp_act_q == $past(wr_data));
    a_r2_spare_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ($stable(ctrl_q) && $stable(cmp_buf_q)));

endmodule

// File: tb/test_tmr8_cmp_pwm.sv
module test_tmr8_cmp_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = 2'd1;
    logic [7:0] rd_data;
    logic       pin_dir = 1'b1;
    logic       port_in = 1'b1;
    logic       pin_out;

    int total = 0;
    int bad = 0;
    int wd = 0;
    string cur_req = "R1";

    int m_ctrl, m_cnt, m_buf, m_ocr, m_oc, m_dir, m_blk, cyc;

    always #4 clk = !clk;

    tmr8_cmp_pwm i_tmr8_cmp_pwm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_dir(pin_dir), .port_in(port_in),
        .pin_out(pin_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ctl(input int pwm, input int clr, input int md, input int cs);
        return pwm | (clr << 1) | (md << 2) | (cs << 4);
    endfunction

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_buf = 0; m_ocr = 0; m_oc = 0; m_dir = 0; m_blk = 0; cyc = 0;
        end else begin
            int cs, div, pwm, clr, md, n_cnt, n_dir, n_ocr, n_oc, n_buf, n_ctrl;
            bit tick, match, load;
            cs = (m_ctrl >> 4) & 7;
            case (cs)
                1: div = 1;
                2: div = 8;
                3: div = 64;
                4: div = 256;
                5: div = 1024;
                default: div = 0;
            endcase
            tick = (div > 0) && (cyc % div == div - 1);
            pwm = m_ctrl & 1; clr = (m_ctrl >> 1) & 1; md = (m_ctrl >> 2) & 3;
            load = wr_en && wr_addr == 2'd1;
            match = tick && !load && !m_blk && m_cnt == m_ocr;
            n_cnt = m_cnt; n_dir = m_dir; n_ocr = m_ocr; n_oc = m_oc; n_buf = m_buf; n_ctrl = m_ctrl;
            if (load) begin
                n_cnt = wr_data;
            end else if (!pwm) begin
                n_dir = 0;
                if (tick) n_cnt = (clr && match) ? 0 : (m_cnt + 1) % 256;
                if (match) begin
                    if (md == 1) n_oc = 1 - m_oc;
                    if (md == 2) n_oc = 0;
                    if (md == 3) n_oc = 1;
                end
            end else if (!clr) begin
                if (tick) begin
                    if (m_dir == 0) begin
                        if (m_cnt == 255) begin n_cnt = 254; n_dir = 1; n_ocr = m_buf; end
                        else n_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin n_cnt = 1; n_dir = 0; end
                        else n_cnt = m_cnt - 1;
                    end
                end
                if (match && md == 2) n_oc = (m_dir == 1) ? 1 : 0;
                if (match && md == 3) n_oc = (m_dir == 0) ? 1 : 0;
            end else begin
                n_dir = 0;
                if (tick) begin
                    n_cnt = (m_cnt + 1) % 256;
                    if (m_cnt == 255 && m_dir == 0) n_ocr = m_buf;
                end
                if (match) begin
                    if (md == 2) n_oc = 0;
                    if (md == 3) n_oc = 1;
                end else if (tick && m_cnt == 255 && m_dir == 0) begin
                    if (md == 2) n_oc = 1;
                    if (md == 3) n_oc = 0;
                end
            end
            if (wr_en && wr_addr == 2'd0) n_ctrl = wr_data & 8'h7F;
            if (wr_en && wr_addr == 2'd2) begin
                n_buf = wr_data;
                if (!pwm) n_ocr = wr_data;
            end
            m_ctrl = n_ctrl; m_cnt = n_cnt; m_dir = n_dir; m_ocr = n_ocr; m_oc = n_oc;
            m_buf = n_buf; m_blk = load; cyc++;
        end
        #3;
        begin
            int exp_rd, exp_pin;
            case (rd_addr)
                2'd0: exp_rd = m_ctrl;
                2'd1: exp_rd = m_cnt;
                2'd2: exp_rd = m_buf;
                default: exp_rd = 0;
            endcase
            exp_pin = (pin_dir && ((m_ctrl >> 2) & 3) != 0) ? m_oc : int'(port_in);
            chk({cur_req, " rd_data"}, int'(rd_data), exp_rd);
            chk({cur_req, " pin_out"}, int'(pin_out), exp_pin);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        rd_addr = 2'(a);
        #1;
        chk(req, int'(rd_data), exp);
        rd_addr = 2'd1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd == 150000) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        rd_chk("R1 ctrl", 0, 0);
        rd_chk("R1 count", 1, 0);
        rd_chk("R1 compare", 2, 0);
        #1 chk("R1 pin", int'(pin_out), 1);

        cur_req = "R4";
        wr(2, 8'h20);
        wr(0, ctl(0, 0, 1, 1));
        wr(1, 8'hF0);
        idle(300);

        cur_req = "R6";
        wr(0, ctl(0, 0, 2, 1)); idle(300);
        wr(0, ctl(0, 0, 3, 1)); idle(300);
        port_in = 1'b0;
        wr(0, ctl(0, 0, 0, 1)); idle(40);

        cur_req = "R5";
        wr(0, ctl(0, 1, 3, 1));
        wr(2, 5);
        wr(1, 3);
        repeat (3) @(posedge clk);
        #3 chk("R5 clear after C", int'(rd_data), 0);
        idle(60);
        wr(0, ctl(0, 1, 1, 2));
        wr(2, 3);
        idle(200);

        cur_req = "R12";
        wr(0, ctl(0, 1, 1, 1));
        wr(2, 10);
        wr(1, 10);
        @(posedge clk);
        #3 chk("R12 blocked match", int'(rd_data), 11);
        idle(300);

        cur_req = "R3";
        wr(0, ctl(0, 0, 1, 3)); idle(1500);
        wr(0, ctl(0, 0, 1, 4)); idle(2000);
        wr(0, ctl(0, 0, 1, 5)); idle(3000);
        wr(0, ctl(0, 0, 1, 6)); idle(300);
        wr(0, ctl(0, 0, 1, 7)); idle(300);
        wr(0, ctl(0, 0, 1, 0)); idle(300);

        cur_req = "R7";
        wr(0, ctl(0, 0, 1, 1));
        pin_dir = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            port_in = !port_in;
        end
        pin_dir = 1'b1;
        idle(20);

        cur_req = "R8";
        wr(2, 8'h40);
        wr(0, ctl(1, 0, 2, 1));
        idle(1100);
        cur_req = "R9";
        wr(0, ctl(1, 0, 3, 1)); idle(1100);
        wr(0, ctl(1, 0, 1, 1)); idle(600);
        wr(0, ctl(1, 0, 3, 1));

        cur_req = "R11";
        wr(2, 8'h90);
        rd_chk("R11 buffered readback", 2, 8'h90);
        idle(1100);

        cur_req = "R10";
        wr(0, ctl(1, 1, 2, 1)); idle(600);
        wr(2, 8'hC0);
        wr(0, ctl(1, 1, 3, 1)); idle(600);
        wr(2, 8'hFF); idle(600);

        cur_req = "R2";
        wr(0, 8'hFF);
        rd_chk("R2 bit7 reads zero", 0, 8'h7F);
        wr(0, ctl(0, 0, 1, 1));
        wr(2, 8'h33);
        wr(3, 8'hAA);
        rd_chk("R2 spare write ignored ctrl", 0, ctl(0, 0, 1, 1));
        rd_chk("R2 spare write ignored cmp", 2, 8'h33);
        rd_chk("R2 spare reads zero", 3, 0);
        idle(20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule